// File: doc/BRIEF.md
# Cache-Block Operation Permission Checker

This block decides whether a cache-block operation issued by a core may execute. The operation is one of four kinds: zero a block, clean it, flush it, or invalidate it. Each request carries the current privilege level, a flag that says whether the hart runs a guest, and the environment-configuration words of the machine, hypervisor and supervisor levels. The block picks the enable field that belongs to the operation from each word. It then applies a fixed-priority rule set and returns one of three verdicts: allow, illegal instruction, or virtual instruction.

The request interface is a single-cycle strobe. One clock after `req_valid`, the block returns a response pulse with the verdict, a fault flag and the matching exception cause code. The same response carries the request address aligned down to the cache-block size, which is a power of two set by a parameter. Address translation, memory-permission probing and the zeroing writes themselves belong to other logic.

Top module: `blkop_permit`

## Requirements
- R1: During and right after reset, `rsp_valid` and `rsp_fault` are 0, `rsp_verdict` is 0 (allow), `rsp_cause` is 0 and `rsp_addr` is 0.
- R2: A response is registered. `rsp_valid` is 1 in the cycle after a cycle with `req_valid` high and 0 otherwise. When no request is presented, the response fields keep their previous values.
- R3: At privilege 3 (machine), every operation is allowed, whatever the configuration words and the guest flag hold.
- R4: At privilege 0 (user) or 1 (supervisor), a clear enable in the machine-level word gives illegal instruction. This rule wins over every later rule, including the guest rules.
- R5: With the guest flag set, passing R4, and the privilege at user or supervisor, a clear enable in the hypervisor-level word gives virtual instruction.
- R6: With the guest flag set, passing R4 and R5, and the privilege at user, a clear enable in the supervisor-level word gives virtual instruction. At supervisor, the supervisor-level word is not consulted.
- R7: With the guest flag clear, the hypervisor-level word has no effect. At user privilege, a clear supervisor-level enable gives illegal instruction. At supervisor privilege, the supervisor-level word has no effect.
- R8: Operation codes are 0 zero, 1 clean, 2 flush and 3 invalidate. Zero uses bit 7 of each word, and clean and flush both use bit 6. Invalidate uses the 2-bit field [5:4], which counts as enabled when it is nonzero.
- R9: Privilege code 2 is reserved and always gives illegal instruction, even when every enable is set.
- R10: `rsp_addr` equals the request address rounded down to a multiple of `BLK_BYTES`, whatever the verdict.
- R11: Verdict codes are 0 allow, 1 illegal and 2 virtual. `rsp_fault` is 1 exactly when the verdict is not allow. `rsp_cause` is 2 for illegal, 22 for virtual and 0 for allow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_priv | input | 2 | Privilege level: 0 user, 1 supervisor, 2 reserved, 3 machine |
| req_virt | input | 1 | Guest (virtualized) execution flag |
| req_op | input | 2 | Operation: 0 zero, 1 clean, 2 flush, 3 invalidate |
| mach_cfg | input | CFG_W | Machine-level environment-configuration word |
| hyp_cfg | input | CFG_W | Hypervisor-level environment-configuration word |
| sup_cfg | input | CFG_W | Supervisor-level environment-configuration word |
| req_addr | input | ADDR_W | Address of the operation |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_verdict | output | 2 | 0 allow, 1 illegal instruction, 2 virtual instruction |
| rsp_fault | output | 1 | High when the verdict is not allow |
| rsp_cause | output | 5 | Exception cause code: 2, 22, or 0 when allowed |
| rsp_addr | output | ADDR_W | Request address aligned down to the block size |

## Verification
The bench targets the priority boundaries.

- When the machine-level enable is clear while the guest flag is set, the result must be illegal instruction. A design that checks the guest rules first would report virtual instruction instead.
- In guest mode at supervisor privilege with only the supervisor-level enable clear, the result must be allow. A design that applies the user-only rule too widely would fault here.
- When the guest flag is clear and only the hypervisor-level enable is clear, the result must also be allow. A design that leaks the hypervisor word into non-guest checks would fault.

Field selection is probed with words that set only the neighbouring bit, and with invalidate fields of 01, 10 and 00. This catches a swapped bit index, and an invalidate test that uses a single bit of the field.

Reserved privilege 2 must be rejected even with every enable set. The address path is checked for all-ones, already-aligned and sub-block addresses. Idle cycles with changing inputs must leave the response untouched.

// File: rtl/blkop_pkg.sv
package blkop_pkg;

  typedef enum logic [1:0] {
    PRIV_USER  = 2'd0,
    PRIV_SUPER = 2'd1,
    PRIV_RSVD  = 2'd2,
    PRIV_MACH  = 2'd3
  } priv_e;

  typedef enum logic [1:0] {
    OP_ZERO  = 2'd0,
    OP_CLEAN = 2'd1,
    OP_FLUSH = 2'd2,
    OP_INVAL = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    VD_ALLOW   = 2'd0,
    VD_ILLEGAL = 2'd1,
    VD_VIRTUAL = 2'd2
  } verdict_e;

  // enable-field positions inside each configuration word
  localparam int INVAL_LO  = 4;
  localparam int INVAL_HI  = 5;
  localparam int CLNFL_BIT = 6;
  localparam int ZERO_BIT  = 7;

  localparam int CAUSE_W = 5;
  localparam logic [CAUSE_W-1:0] CAUSE_ILLEGAL = 5'd2;
  localparam logic [CAUSE_W-1:0] CAUSE_VIRTUAL = 5'd22;

  function automatic logic [CAUSE_W-1:0] cause_of(verdict_e v);
    case (v)
      VD_ILLEGAL: cause_of = CAUSE_ILLEGAL;
      VD_VIRTUAL: cause_of = CAUSE_VIRTUAL;
      default:    cause_of = '0;
    endcase
  endfunction

endpackage

// File: rtl/blkop_enable_sel.sv
module blkop_enable_sel
  import blkop_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  op_e              op,
  input  logic [CFG_W-1:0] cfg,
  output logic             en
);

  // pick the enable that governs this operation kind
  function automatic logic pick_enable(op_e o, logic [CFG_W-1:0] c);
    case (o)
      OP_ZERO:           pick_enable = c[ZERO_BIT];
      OP_CLEAN, OP_FLUSH: pick_enable = c[CLNFL_BIT];
      default:           pick_enable = |c[INVAL_HI:INVAL_LO];
    endcase
  endfunction

  assign en = pick_enable(op, cfg);

endmodule

// File: rtl/blkop_rule.sv
module blkop_rule
  import blkop_pkg::*;
(
  input  priv_e    priv,
  input  logic     virt,
  input  logic     m_en,
  input  logic     h_en,
  input  logic     s_en,
  output logic     hit_rsvd,
  output logic     hit_mach,
  output logic     hit_virt,
  output logic     hit_super,
  output verdict_e verdict
);

  logic below_mach;

  assign below_mach = (priv == PRIV_USER) || (priv == PRIV_SUPER);
  assign hit_rsvd   = (priv == PRIV_RSVD);
  assign hit_mach   = below_mach && !m_en;
  assign hit_virt   = virt && below_mach &&
                      (!h_en || ((priv == PRIV_USER) && !s_en));
  assign hit_super  = (priv == PRIV_USER) && !s_en;

  // fixed priority: reserved level, machine word, guest rules, supervisor word
  always_comb begin
    if (hit_rsvd)       verdict = VD_ILLEGAL;
    else if (hit_mach)  verdict = VD_ILLEGAL;
    else if (hit_virt)  verdict = VD_VIRTUAL;
    else if (hit_super) verdict = VD_ILLEGAL;
    else                verdict = VD_ALLOW;
  end

endmodule

// File: rtl/blkop_align.sv
module blkop_align #(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64
) (
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] addr_out
);

  localparam int OFS_W = $clog2(BLK_BYTES);
  localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << OFS_W) - 1);

  function automatic logic [ADDR_W-1:0] align_down(logic [ADDR_W-1:0] a);
    align_down = a & ~LOW_MASK;
  endfunction

  assign addr_out = align_down(addr_in);

endmodule

// File: rtl/blkop_permit.sv
module blkop_permit
  import blkop_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int BLK_BYTES = 64,
  parameter int CFG_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_priv,
  input  logic              req_virt,
  input  logic [1:0]        req_op,
  input  logic [CFG_W-1:0]  mach_cfg,
  input  logic [CFG_W-1:0]  hyp_cfg,
  input  logic [CFG_W-1:0]  sup_cfg,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic [1:0]        rsp_verdict,
  output logic              rsp_fault,
  output logic [4:0]        rsp_cause,
  output logic [ADDR_W-1:0] rsp_addr
);

  localparam int OFS_W  = $clog2(BLK_BYTES);
  localparam int N_LVLS = 3;  // 0 machine, 1 hypervisor, 2 supervisor

  priv_e    priv_q;
  op_e      op_q;
  verdict_e verdict_c;
  logic [N_LVLS-1:0][CFG_W-1:0] cfg_lvls;
  logic [N_LVLS-1:0]            en_lvls;
  logic m_en, h_en, s_en;
  logic hit_rsvd, hit_mach, hit_virt, hit_super;
  logic [ADDR_W-1:0] aligned_c;

  assign priv_q   = priv_e'(req_priv);
  assign op_q     = op_e'(req_op);
  assign cfg_lvls = {sup_cfg, hyp_cfg, mach_cfg};

  for (genvar g = 0; g < N_LVLS; g++) begin : g_lvl
    blkop_enable_sel #(.CFG_W(CFG_W)) u_sel (
      .op  (op_q),
      .cfg (cfg_lvls[g]),
      .en  (en_lvls[g])
    );
  end

  assign m_en = en_lvls[0];
  assign h_en = en_lvls[1];
  assign s_en = en_lvls[2];

  blkop_rule u_rule (
    .priv      (priv_q),
    .virt      (req_virt),
    .m_en      (m_en),
    .h_en      (h_en),
    .s_en      (s_en),
    .hit_rsvd  (hit_rsvd),
    .hit_mach  (hit_mach),
    .hit_virt  (hit_virt),
    .hit_super (hit_super),
    .verdict   (verdict_c)
  );

  blkop_align #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_align (
    .addr_in  (req_addr),
    .addr_out (aligned_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid   <= 1'b0;
      rsp_verdict <= VD_ALLOW;
      rsp_fault   <= 1'b0;
      rsp_cause   <= '0;
      rsp_addr    <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_verdict <= verdict_c;
        rsp_fault   <= (verdict_c != VD_ALLOW);
        rsp_cause   <= cause_of(verdict_c);
        rsp_addr    <= aligned_c;
      end
    end
  end

  // R2: one response per request, one cycle later
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && $stable(rsp_verdict) && $stable(rsp_addr)));

  // R3: machine level always allowed
  p_mach_allow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_priv == 2'd3) |=> (rsp_verdict == VD_ALLOW));

  // R4: a clear machine-level enable below machine is illegal, ahead of guest rules
  p_mach_cfg_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_mach) |=> (rsp_verdict == VD_ILLEGAL));

  // R5/R6: a guest fault only with the guest flag set
  p_virt_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_virt) |=> (rsp_verdict != VD_VIRTUAL));

  // R9: reserved level rejected
  p_rsvd_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && hit_rsvd) |=> (rsp_verdict == VD_ILLEGAL));

  // R10: response address has no offset bits
  p_align_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_addr[OFS_W-1:0] == '0));

  // R11: fault flag and cause agree
  p_cause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault |-> (rsp_cause == CAUSE_ILLEGAL || rsp_cause == CAUSE_VIRTUAL));
  p_nocause_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !rsp_fault |-> (rsp_cause == '0));

endmodule

// File: tb/blkop_permit_test.sv
module blkop_permit_test;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 32;
  localparam int BLK        = 64;
  localparam int CFG_W      = 8;
  localparam int NVEC       = 18;

  // {req tag[34:31], priv[30:29], virt[28], op[27:26], mach[25:18], hyp[17:10], sup[9:2], expected verdict[1:0]}
  // verdicts: 0 allow, 1 illegal, 2 virtual; ops: 0 zero, 1 clean, 2 flush, 3 invalidate
  localparam logic [34:0] VECS [NVEC] = '{
    {4'd3, 2'd3, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 2'd0},  // R3 machine, nothing set
    {4'd3, 2'd3, 1'b1, 2'd3, 8'h00, 8'h00, 8'h00, 2'd0},  // R3 machine with guest flag
    {4'd4, 2'd1, 1'b0, 2'd0, 8'h00, 8'hF0, 8'hF0, 2'd1},  // R4 supervisor
    {4'd4, 2'd0, 1'b1, 2'd1, 8'h00, 8'h00, 8'h00, 2'd1},  // R4 wins over guest rules
    {4'd5, 2'd1, 1'b1, 2'd0, 8'hF0, 8'h00, 8'hF0, 2'd2},  // R5 guest supervisor
    {4'd5, 2'd0, 1'b1, 2'd0, 8'hF0, 8'h00, 8'hF0, 2'd2},  // R5 guest user
    {4'd6, 2'd0, 1'b1, 2'd2, 8'hF0, 8'hF0, 8'h00, 2'd2},  // R6 guest user, sup clear
    {4'd6, 2'd1, 1'b1, 2'd2, 8'hF0, 8'hF0, 8'h00, 2'd0},  // R6 guest supervisor ignores sup
    {4'd7, 2'd0, 1'b0, 2'd0, 8'hF0, 8'h00, 8'h00, 2'd1},  // R7 user, sup clear
    {4'd7, 2'd1, 1'b0, 2'd0, 8'hF0, 8'h00, 8'h00, 2'd0},  // R7 supervisor, hyp and sup ignored
    {4'd7, 2'd0, 1'b0, 2'd1, 8'hF0, 8'h00, 8'hF0, 2'd0},  // R7 hyp ignored without guest
    {4'd8, 2'd0, 1'b0, 2'd3, 8'h10, 8'h00, 8'h20, 2'd0},  // R8 invalidate fields 01 and 10
    {4'd8, 2'd0, 1'b0, 2'd3, 8'h30, 8'h00, 8'hC0, 2'd1},  // R8 invalidate field 00 in sup
    {4'd8, 2'd1, 1'b0, 2'd0, 8'h40, 8'h00, 8'h00, 2'd1},  // R8 zero needs bit 7
    {4'd8, 2'd1, 1'b0, 2'd1, 8'h40, 8'h00, 8'h00, 2'd0},  // R8 clean uses bit 6
    {4'd8, 2'd1, 1'b0, 2'd2, 8'h80, 8'h00, 8'h00, 2'd1},  // R8 flush not on bit 7
    {4'd9, 2'd2, 1'b0, 2'd0, 8'hF0, 8'hF0, 8'hF0, 2'd1},  // R9 reserved, all enabled
    {4'd9, 2'd2, 1'b1, 2'd3, 8'hF0, 8'hF0, 8'hF0, 2'd1}   // R9 reserved with guest flag
  };

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic [1:0]        req_priv;
  logic              req_virt;
  logic [1:0]        req_op;
  logic [CFG_W-1:0]  mach_cfg, hyp_cfg, sup_cfg;
  logic [ADDR_W-1:0] req_addr;
  logic              rsp_valid;
  logic [1:0]        rsp_verdict;
  logic              rsp_fault;
  logic [4:0]        rsp_cause;
  logic [ADDR_W-1:0] rsp_addr;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  blkop_permit #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK), .CFG_W(CFG_W)) uut (
    .clk, .rst_n, .req_valid, .req_priv, .req_virt, .req_op,
    .mach_cfg, .hyp_cfg, .sup_cfg, .req_addr,
    .rsp_valid, .rsp_verdict, .rsp_fault, .rsp_cause, .rsp_addr
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [ADDR_W-1:0] exp_addr(logic [ADDR_W-1:0] a);
    return a - (a % BLK);
  endfunction

  function automatic logic [4:0] exp_cause(logic [1:0] v);
    return (v == 2'd1) ? 5'd2 : (v == 2'd2) ? 5'd22 : 5'd0;
  endfunction

  task automatic drive(input logic v, input logic [1:0] p, input logic g,
                       input logic [1:0] o, input logic [7:0] m,
                       input logic [7:0] h, input logic [7:0] s,
                       input logic [ADDR_W-1:0] a);
    req_valid = v; req_priv = p; req_virt = g; req_op = o;
    mach_cfg = m; hyp_cfg = h; sup_cfg = s; req_addr = a;
  endtask

  task automatic chk_resp(input string req, input logic [1:0] v,
                          input logic [ADDR_W-1:0] a);
    chk(req, "valid", 64'(rsp_valid), 64'd1);
    chk(req, "verdict", 64'(rsp_verdict), 64'(v));
    chk("R11", "fault", 64'(rsp_fault), 64'(v != 2'd0));
    chk("R11", "cause", 64'(rsp_cause), 64'(exp_cause(v)));
    chk("R10", "addr", 64'(rsp_addr), 64'(exp_addr(a)));
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [ADDR_W-1:0] a;
    rst_n = 1'b0;
    drive(1'b0, 2'd0, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, '0);
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1", "valid", 64'(rsp_valid), 64'd0);
    chk("R1", "verdict", 64'(rsp_verdict), 64'd0);
    chk("R1", "fault", 64'(rsp_fault), 64'd0);
    chk("R1", "cause", 64'(rsp_cause), 64'd0);
    chk("R1", "addr", 64'(rsp_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "valid after release", 64'(rsp_valid), 64'd0);

    // table walk, back to back requests (R2)
    for (int i = 0; i < NVEC; i++) begin
      logic [34:0] e;
      e = VECS[i];
      a = 32'hDEAD_BEEF ^ (32'(i) * 32'h1357_9BDF);
      drive(1'b1, e[30:29], e[28], e[27:26], e[25:18], e[17:10], e[9:2], a);
      @(negedge clk);
      chk_resp($sformatf("R%0d vec%0d", e[34:31], i), e[1:0], a);
    end

    // R2 idle cycles: inputs change, response holds
    drive(1'b0, 2'd0, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 32'h1234_5678);
    @(negedge clk);
    chk("R2", "idle valid", 64'(rsp_valid), 64'd0);
    chk("R2", "idle verdict hold", 64'(rsp_verdict), 64'd1);
    chk("R2", "idle addr hold", 64'(rsp_addr), 64'(exp_addr(a)));
    @(negedge clk);
    chk("R2", "idle valid 2", 64'(rsp_valid), 64'd0);

    // R10 address corners
    drive(1'b1, 2'd3, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 32'hFFFF_FFFF);
    @(negedge clk);
    chk_resp("R10 all ones", 2'd0, 32'hFFFF_FFFF);
    drive(1'b1, 2'd0, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, 32'h0000_1000);
    @(negedge clk);
    chk_resp("R10 aligned, faulting", 2'd1, 32'h0000_1000);
    drive(1'b1, 2'd1, 1'b1, 2'd3, 8'h30, 8'h00, 8'h30, 32'h0000_003F);
    @(negedge clk);
    chk_resp("R10 sub-block", 2'd2, 32'h0000_003F);
    chk("R10", "sub-block zero", 64'(rsp_addr), 64'd0);

    // R2 single pulse after last request
    drive(1'b0, 2'd0, 1'b0, 2'd0, 8'h00, 8'h00, 8'h00, '0);
    @(negedge clk);
    chk("R2", "pulse ends", 64'(rsp_valid), 64'd0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule